// File: doc/BRIEF.md
# Memory-Mapped Console Port

This block sits on a simple processor bus as a slave and gives software a character console: a keyboard side that captures incoming characters and a display side that hands outgoing characters to a downstream sink. Software sees four 32-bit registers in a 16-byte window at a parameterised base address. Each direction has one control word and one data word.

Incoming characters arrive as single-cycle strobes with a byte. They are held in a one-character slot until software reads them. Outgoing characters are written by software into a one-character slot. That slot is offered on a valid/ready output until the sink takes it. Each direction can raise a shared interrupt line when it is ready and its enable bit is set.

Top module: `mmio_console`

## Requirements
- R1: After reset, the receive control word reads 0, the transmit control word reads 1, `irq` is 0 and `disp_valid` is 0.
- R2: Register offsets from the base are: 0x0 receive control, 0x4 receive data, 0x8 transmit control, 0xC transmit data. In both control words bit 0 is the ready flag and bit 1 is the interrupt enable, and all other bits read 0. A write to a control word changes only bit 1, and bit 0 ignores the written value.
- R3: A cycle with `kbd_valid` high stores `kbd_byte` and sets receive ready. The receive data word then returns the byte in bits 7:0, with zeros above.
- R4: A read of the receive data word clears receive ready on the following edge. If a byte arrives in the same cycle as that read, receive ready stays set.
- R5: A byte that arrives while receive ready is still set replaces the held byte.
- R6: A write to the transmit data word while transmit ready is 1 stores `bus_wdata[7:0]`. On the next edge, transmit ready reads 0, `disp_valid` rises and `disp_byte` shows that byte.
- R7: `disp_valid` and `disp_byte` hold steady until a cycle with `disp_ready` high. After that cycle, `disp_valid` is 0 and transmit ready reads 1.
- R8: A write to the transmit data word while transmit ready is 0 is ignored, and the character in flight is unchanged.
- R9: `irq` is high exactly when (receive ready and receive enable) or (transmit ready and transmit enable).
- R10: An access outside the 16-byte window reads 0 and has no effect: it does not clear receive ready and it does not change any register. A read of the transmit data word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| kbd_valid | input | 1 | One-cycle strobe: a character has arrived |
| kbd_byte | input | 8 | Arriving character |
| disp_valid | output | 1 | A character is offered to the display |
| disp_byte | output | 8 | Offered character |
| disp_ready | input | 1 | Display accepts the offered character |
| irq | output | 1 | Combined interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a character arriving in the same cycle as the read that would clear receive ready. The bench drives `kbd_valid` and the data-word read on the same falling edge, then reads the control word to confirm the flag survived. The second is a write landing while a character is still in flight. The bench holds `disp_ready` low to stall the sink, writes a second character, and lets the scoreboard confirm that only the first character ever leaves.

// File: rtl/mmio_console_pkg.sv
// Package: shared register selectors, control-bit positions and access strobes
// for the console port. Assumes a 16-byte window of four word registers.
package mmio_console_pkg;

    typedef enum logic [1:0] {
        SEL_RX_CTRL = 2'd0,
        SEL_RX_DATA = 2'd1,
        SEL_TX_CTRL = 2'd2,
        SEL_TX_DATA = 2'd3
    } con_sel_e;

    localparam int RDY_BIT = 0;
    localparam int IE_BIT  = 1;

    typedef struct packed {
        logic rd_rx_data;
        logic wr_rx_ctrl;
        logic wr_tx_ctrl;
        logic wr_tx_data;
    } con_strobe_t;

endpackage

// File: rtl/con_addr_decode.sv
// Address decoder: matches the 16-byte window at BASE and turns bus strobes
// into per-register strobes. Assumes word-aligned accesses; bits 1:0 are ignored.
module con_addr_decode
    import mmio_console_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              hit,
    output con_sel_e          sel,
    output con_strobe_t       stb
);
    localparam int WIN_LSB = 4;
    localparam int SEL_LSB = 2;

    // Window match and register selection.
    always_comb begin
        hit = (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
        sel = con_sel_e'(addr[SEL_LSB+1:SEL_LSB]);
        stb.rd_rx_data = hit && rd && (sel == SEL_RX_DATA);
        stb.wr_rx_ctrl = hit && wr && (sel == SEL_RX_CTRL);
        stb.wr_tx_ctrl = hit && wr && (sel == SEL_TX_CTRL);
        stb.wr_tx_data = hit && wr && (sel == SEL_TX_DATA);
    end
endmodule

// File: rtl/con_rx_slot.sv
// Receive slot: holds one character, a ready flag and an interrupt enable.
// An arrival outranks a clearing read in the same cycle.
module con_rx_slot #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_byte,
    input  logic              clr,
    input  logic              ie_wr,
    input  logic              ie_val,
    output logic              rdy,
    output logic              ie,
    output logic [CHAR_W-1:0] held
);
    // Capture arrivals and track the ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy  <= 1'b0;
            held <= '0;
        end else if (in_valid) begin
            rdy  <= 1'b1;
            held <= in_byte;
        end else if (clr) begin
            rdy  <= 1'b0;
        end
    end

    // Interrupt-enable bit written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie <= 1'b0;
        else if (ie_wr) ie <= ie_val;
    end
endmodule

// File: rtl/con_tx_slot.sv
// Transmit slot: accepts one character from software when ready and offers it
// on a valid/ready output until taken. Loads while busy are dropped.
module con_tx_slot #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_byte,
    input  logic              ie_wr,
    input  logic              ie_val,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_byte,
    output logic              rdy,
    output logic              ie
);
    // Load on a write when idle, release when the sink takes the character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy      <= 1'b1;
            out_byte <= '0;
        end else if (rdy && load) begin
            rdy      <= 1'b0;
            out_byte <= load_byte;
        end else if (!rdy && out_ready) begin
            rdy      <= 1'b1;
        end
    end

    // Interrupt-enable bit written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie <= 1'b0;
        else if (ie_wr) ie <= ie_val;
    end

    // A character is on offer whenever the slot is not ready.
    always_comb out_valid = !rdy;
endmodule

// File: rtl/mmio_console.sv
// Console port top: bus slave exposing receive and transmit slots through
// four word registers, plus a combined interrupt. Read data is combinational
// in the cycle of the read strobe; side effects land on the following edge.
module mmio_console
    import mmio_console_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter int                DATA_W = 32,
    parameter int                CHAR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kbd_valid,
    input  logic [CHAR_W-1:0] kbd_byte,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_byte,
    input  logic              disp_ready,
    output logic              irq
);
    logic              hit;
    con_sel_e          sel;
    con_strobe_t       stb;
    logic              rx_rdy, rx_ie, tx_rdy, tx_ie;
    logic [CHAR_W-1:0] rx_byte;

    con_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .hit  (hit),
        .sel  (sel),
        .stb  (stb)
    );

    con_rx_slot #(.CHAR_W(CHAR_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (kbd_valid),
        .in_byte  (kbd_byte),
        .clr      (stb.rd_rx_data),
        .ie_wr    (stb.wr_rx_ctrl),
        .ie_val   (bus_wdata[IE_BIT]),
        .rdy      (rx_rdy),
        .ie       (rx_ie),
        .held     (rx_byte)
    );

    con_tx_slot #(.CHAR_W(CHAR_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (stb.wr_tx_data),
        .load_byte (bus_wdata[CHAR_W-1:0]),
        .ie_wr     (stb.wr_tx_ctrl),
        .ie_val    (bus_wdata[IE_BIT]),
        .out_ready (disp_ready),
        .out_valid (disp_valid),
        .out_byte  (disp_byte),
        .rdy       (tx_rdy),
        .ie        (tx_ie)
    );

    // Read multiplexer: control words carry ready and enable, data words a byte.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && hit) begin
            unique case (sel)
                SEL_RX_CTRL: begin
                    bus_rdata[RDY_BIT] = rx_rdy;
                    bus_rdata[IE_BIT]  = rx_ie;
                end
                SEL_RX_DATA: bus_rdata[CHAR_W-1:0] = rx_byte;
                SEL_TX_CTRL: begin
                    bus_rdata[RDY_BIT] = tx_rdy;
                    bus_rdata[IE_BIT]  = tx_ie;
                end
                default:     bus_rdata = '0;
            endcase
        end
    end

    // Interrupt combines the two enabled ready conditions.
    always_comb irq = (rx_rdy && rx_ie) || (tx_rdy && tx_ie);
endmodule

// File: rtl/mmio_console_chk.sv
// Checker for mmio_console: observes the bus, both byte streams and the
// receive slot state. Bound to every instance of the top module below.
module mmio_console_chk #(
    parameter int                ADDR_W = 32,
    parameter int                DATA_W = 32,
    parameter int                CHAR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              kbd_valid,
    input logic [CHAR_W-1:0] kbd_byte,
    input logic              disp_valid,
    input logic [CHAR_W-1:0] disp_byte,
    input logic              disp_ready,
    input logic              irq,
    input logic              rx_rdy,
    input logic [CHAR_W-1:0] rx_byte
);
    logic in_win;
    always_comb in_win = (bus_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);

    // R3
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_valid |=> rx_rdy && (rx_byte == $past(kbd_byte)));

    // R4
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_win && bus_addr[3:2] == 2'd1 && !kbd_valid) |=> !rx_rdy);

    // R6
    tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_win && bus_addr[3:2] == 2'd3 && !disp_valid)
        |=> disp_valid && (disp_byte == $past(bus_wdata[CHAR_W-1:0])));

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> disp_valid && $stable(disp_byte));

    // R7
    tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> !disp_valid);

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_rdy || !disp_valid));
endmodule

bind mmio_console mmio_console_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CHAR_W (CHAR_W),
    .BASE   (BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .kbd_valid  (kbd_valid),
    .kbd_byte   (kbd_byte),
    .disp_valid (disp_valid),
    .disp_byte  (disp_byte),
    .disp_ready (disp_ready),
    .irq        (irq),
    .rx_rdy     (rx_rdy),
    .rx_byte    (rx_byte)
);

// File: tb/mmio_console_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for mmio_console: the write task queues expected display
// characters, a monitor pops them on every display handshake.
module mmio_console_bench;
    localparam logic [31:0] B = 32'hFFFF_0000;
    localparam logic [31:0] A_RXC = B + 32'h0;
    localparam logic [31:0] A_RXD = B + 32'h4;
    localparam logic [31:0] A_TXC = B + 32'h8;
    localparam logic [31:0] A_TXD = B + 32'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        kbd_valid = 1'b0;
    logic [7:0]  kbd_byte = '0;
    logic        disp_valid;
    logic [7:0]  disp_byte;
    logic        disp_ready = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];
    logic [31:0] rd;

    mmio_console u_mmio_console (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_valid(kbd_valid), .kbd_byte(kbd_byte), .disp_valid(disp_valid),
        .disp_byte(disp_byte), .disp_ready(disp_ready), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Driver: a write to the transmit data word queues the expected character.
    task automatic send_char(input logic [31:0] d);
        exp_q.push_back(d[7:0]);
        bus_write(A_TXD, d);
    endtask

    task automatic kbd_send(input logic [7:0] b);
        @(negedge clk);
        kbd_valid = 1'b1; kbd_byte = b;
        @(negedge clk);
        kbd_valid = 1'b0;
    endtask

    task automatic set_sink(input logic r);
        @(posedge clk);
        #1 disp_ready = r;
    endtask

    // Monitor: every accepted display character must match the queue head (R7).
    always @(negedge clk) begin
        if (rst_n && disp_valid && disp_ready) begin
            if (exp_q.size() == 0)
                check(1'b0, "R8 unexpected char", {24'd0, disp_byte}, 32'd0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(disp_byte == e, "R7 display char", {24'd0, disp_byte}, {24'd0, e});
            end
        end
    end

    // Watchdog.
    initial begin
        #200000;
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1 check(irq == 1'b0, "R1 irq", {31'd0, irq}, 0);
        check(disp_valid == 1'b0, "R1 disp_valid", {31'd0, disp_valid}, 0);
        bus_read(A_RXC, rd); check(rd == 32'd0, "R1 rx ctrl", rd, 0);
        bus_read(A_TXC, rd); check(rd == 32'd1, "R1 tx ctrl", rd, 1);

        // R2 control bits
        bus_write(A_TXC, 32'hFFFF_FFFF);
        bus_read(A_TXC, rd); check(rd == 32'd3, "R2 tx ctrl all ones", rd, 3);
        #1 check(irq == 1'b1, "R9 tx irq", {31'd0, irq}, 1);
        bus_write(A_TXC, 32'h0);
        bus_read(A_TXC, rd); check(rd == 32'd1, "R2 tx ctrl cleared ie", rd, 1);
        bus_write(A_RXC, 32'h1);
        bus_read(A_RXC, rd); check(rd == 32'd0, "R2 rx ready not writable", rd, 0);

        // R3 arrival
        kbd_send(8'hA5);
        bus_read(A_RXC, rd); check(rd == 32'd1, "R3 rx ready set", rd, 1);
        bus_read(A_RXD, rd); check(rd == 32'h0000_00A5, "R3 rx data", rd, 32'hA5);
        bus_read(A_RXC, rd); check(rd == 32'd0, "R4 rx ready cleared", rd, 0);

        // R5 overwrite
        kbd_send(8'h11);
        kbd_send(8'h22);
        bus_read(A_RXD, rd); check(rd == 32'h22, "R5 overwrite", rd, 32'h22);

        // R4 arrival in the same cycle as the clearing read
        @(negedge clk);
        kbd_valid = 1'b1; kbd_byte = 8'h5C; bus_addr = A_RXD; bus_rd = 1'b1;
        @(negedge clk);
        kbd_valid = 1'b0; bus_rd = 1'b0;
        bus_read(A_RXC, rd); check(rd == 32'd1, "R4 arrival beats read", rd, 1);
        bus_read(A_RXD, rd); check(rd == 32'h5C, "R4 new byte kept", rd, 32'h5C);

        // R9 receive interrupt
        bus_write(A_RXC, 32'h2);
        #1 check(irq == 1'b0, "R9 rx irq idle", {31'd0, irq}, 0);
        kbd_send(8'h7E);
        #1 check(irq == 1'b1, "R9 rx irq raised", {31'd0, irq}, 1);
        bus_read(A_RXD, rd);
        #1 check(irq == 1'b0, "R9 rx irq after read", {31'd0, irq}, 0);
        bus_write(A_RXC, 32'h0);

        // R6 / R8 stalled transmit
        send_char(32'h1234_5641);
        bus_read(A_TXC, rd); check(rd == 32'd0, "R6 tx busy", rd, 0);
        check(disp_valid && disp_byte == 8'h41, "R6 disp byte", {24'd0, disp_byte}, 32'h41);
        bus_write(A_TXD, 32'h99);
        repeat (3) @(negedge clk);
        check(disp_byte == 8'h41, "R8 busy write ignored", {24'd0, disp_byte}, 32'h41);
        bus_write(A_TXC, 32'h2);
        #1 check(irq == 1'b0, "R9 tx irq while busy", {31'd0, irq}, 0);
        set_sink(1'b1);
        repeat (2) @(negedge clk);
        check(disp_valid == 1'b0, "R7 valid dropped", {31'd0, disp_valid}, 0);
        bus_read(A_TXC, rd); check(rd == 32'd3, "R7 tx ready back", rd, 3);
        check(irq == 1'b1, "R9 tx irq ready", {31'd0, irq}, 1);
        bus_write(A_TXC, 32'h0);

        // R6 / R7 stream of characters with the sink open
        for (int i = 0; i < 6; i++) begin
            send_char(32'h30 + i);
            for (int k = 0; k < 10; k++) begin
                bus_read(A_TXC, rd);
                if (rd[0]) break;
            end
            check(rd[0] == 1'b1, "R7 ready after stream char", rd, 1);
        end

        // R10 outside the window
        kbd_send(8'h66);
        bus_read(32'h1000_0004, rd); check(rd == 32'd0, "R10 outside read", rd, 0);
        bus_read(A_RXC, rd); check(rd == 32'd1, "R10 rx ready kept", rd, 1);
        bus_write(32'h0000_0008, 32'h2);
        bus_read(A_TXC, rd); check(rd == 32'd1, "R10 outside write", rd, 1);
        bus_read(A_TXD, rd); check(rd == 32'd0, "R10 tx data reads zero", rd, 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule